// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This unit turns up to 32 asynchronous input pins into a single interrupt request. Each pin has its own sense mode, held in a 2-bit field: any edge, rising-or-high, falling-or-low, or disabled. A per-pin kind bit decides whether the rising-or-high and falling-or-low modes act on an edge or on a level. Each pin is first passed through a two-flop synchroniser. Edge events are latched in a pending register that software clears by writing ones to it. A level condition drives its pending bit directly, so that bit stays set for as long as the condition holds.

The mode fields are packed 16 to a 32-bit word. Pins 0 to 15 use the word at offset 0x14 and pins 16 to 31 use the word at offset 0x18. The lowest pin of each word sits in the top two bits. A mask register selects which pending bits reach the single interrupt output. Software configures and services the unit through a simple write-strobe register port with combinational read data.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset, the pending, mask, kind and both mode words read as zero, and `irq_o` is low. Every pin therefore starts in any-edge mode and masked.
- R2: The register offsets are: pending 0x00, mask 0x04, kind 0x08, mode word for pins 0-15 at 0x14, mode word for pins 16-31 at 0x18. Mask, kind and both mode words read back what was written. Any other offset reads zero and ignores writes.
- R3: In the pending, mask and kind registers, pin n maps to bit 31-n. The mode field of pin p occupies bits (15 - p mod 16)*2 + 1 down to (15 - p mod 16)*2 of its word.
- R4: Mode 00 sets the pending bit on every rising and every falling edge, whatever the pin's kind bit says.
- R5: With kind 0 (edge), mode 01 sets pending on a rising edge only, and mode 10 sets pending on a falling edge only.
- R6: With kind 1 (level), mode 01 makes the pending bit follow "pin high" and mode 10 makes it follow "pin low". Writing one to clear it has no effect while the condition holds. The bit drops by itself once the condition ends.
- R7: Mode 11 never sets a pending bit, in either kind.
- R8: For edge-sensed pins, writing a one to a pending bit clears it and writing a zero leaves it unchanged. If an edge event arrives in the same cycle as the clear, the pending bit stays set.
- R9: `irq_o` is high exactly when some pin has both its pending bit and its mask bit set.
- R10: A pin change applied before clock edge k shows in the pending register after edge k+2, never earlier. Changing a pin's mode or kind while its input is steady creates no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs, pin n on bit n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
A wrong mode decode or a wrong field position shows up as a pending bit set at the wrong pin index, or not set at all. This appears in the pending readback three clocks after the pin change, and in `irq_o` within the same cycle once the pin is unmasked. A lost event during a simultaneous clear, or a level bit that gives way to a write-one-to-clear, shows in the very next read of the pending register. For that reason the tests read pending immediately after the edge on which the clear and the event meet, and they check the latency cycle by cycle.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SENSE_ANY = 2'b00,
    SENSE_HI  = 2'b01,
    SENSE_LO  = 2'b10,
    SENSE_OFF = 2'b11
  } sense_e;

  localparam logic [4:0] OFS_PEND    = 5'h00;
  localparam logic [4:0] OFS_MASK    = 5'h04;
  localparam logic [4:0] OFS_KIND    = 5'h08;
  localparam logic [4:0] OFS_MODE_LO = 5'h14;
  localparam logic [4:0] OFS_MODE_HI = 5'h18;
endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pis_detect.sv
module pis_detect
  import pis_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]             cur_i,
  input  logic [NUM_PINS-1:0]             prev_i,
  input  logic [NUM_PINS-1:0][MODE_W-1:0] mode_i,
  input  logic [NUM_PINS-1:0]             kind_i,
  output logic [NUM_PINS-1:0]             evt_o,
  output logic [NUM_PINS-1:0]             lvl_act_o,
  output logic [NUM_PINS-1:0]             cond_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise = cur_i[p] & ~prev_i[p];
    assign fall = ~cur_i[p] & prev_i[p];

    always_comb begin
      evt_o[p]     = 1'b0;
      lvl_act_o[p] = 1'b0;
      cond_o[p]    = 1'b0;
      unique case (sense_e'(mode_i[p]))
        SENSE_ANY: evt_o[p] = rise | fall;
        SENSE_HI: begin
          lvl_act_o[p] = kind_i[p];
          cond_o[p]    = cur_i[p];
          evt_o[p]     = ~kind_i[p] & rise;
        end
        SENSE_LO: begin
          lvl_act_o[p] = kind_i[p];
          cond_o[p]    = ~cur_i[p];
          evt_o[p]     = ~kind_i[p] & fall;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pis_pending.sv
module pis_pending #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] lvl_act_i,
  input  logic [NUM_PINS-1:0] cond_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] pend_q, pend_d;

  // level pins mirror the condition; edge pins latch, event beats clear
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (lvl_act_i[p]) pend_d[p] = cond_i[p];
      else              pend_d[p] = (pend_q[p] & ~clr_i[p]) | evt_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pis_regs.sv
module pis_regs
  import pis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_PINS-1:0]             pend_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_PINS-1:0]             mask_o,
  output logic [NUM_PINS-1:0]             kind_o,
  output logic [NUM_PINS-1:0][MODE_W-1:0] mode_o,
  output logic [NUM_PINS-1:0]             clr_o
);
  localparam int FIELDS = DATA_W / MODE_W;

  logic [DATA_W-1:0] mask_q, kind_q, mode_lo_q, mode_hi_q, pend_view;
  logic wr_pend, wr_mask, wr_kind, wr_lo, wr_hi;

  assign wr_pend = we_i && (addr_i == ADDR_W'(OFS_PEND));
  assign wr_mask = we_i && (addr_i == ADDR_W'(OFS_MASK));
  assign wr_kind = we_i && (addr_i == ADDR_W'(OFS_KIND));
  assign wr_lo   = we_i && (addr_i == ADDR_W'(OFS_MODE_LO));
  assign wr_hi   = we_i && (addr_i == ADDR_W'(OFS_MODE_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      kind_q    <= '0;
      mode_lo_q <= '0;
      mode_hi_q <= '0;
    end else begin
      if (wr_mask) mask_q    <= wdata_i;
      if (wr_kind) kind_q    <= wdata_i;
      if (wr_lo)   mode_lo_q <= wdata_i;
      if (wr_hi)   mode_hi_q <= wdata_i;
    end
  end

  // pin p lives at register bit DATA_W-1-p
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    assign mask_o[p] = mask_q[DATA_W-1-p];
    assign kind_o[p] = kind_q[DATA_W-1-p];
    assign clr_o[p]  = wr_pend & wdata_i[DATA_W-1-p];
    if (p < FIELDS) begin : g_lo
      assign mode_o[p] = mode_lo_q[(FIELDS-1-p)*MODE_W +: MODE_W];
    end else begin : g_hi
      assign mode_o[p] = mode_hi_q[(FIELDS-1-(p-FIELDS))*MODE_W +: MODE_W];
    end
  end

  always_comb begin
    pend_view = '0;
    for (int p = 0; p < NUM_PINS; p++) pend_view[DATA_W-1-p] = pend_i[p];
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_PEND):    rdata_o = pend_view;
      ADDR_W'(OFS_MASK):    rdata_o = mask_q;
      ADDR_W'(OFS_KIND):    rdata_o = kind_q;
      ADDR_W'(OFS_MODE_LO): rdata_o = mode_lo_q;
      ADDR_W'(OFS_MODE_HI): rdata_o = mode_hi_q;
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]             cur_pin, prev_pin;
  logic [NUM_PINS-1:0][MODE_W-1:0] mode_pin;
  logic [NUM_PINS-1:0]             kind_pin, mask_pin, clr_pin, pend_pin;
  logic [NUM_PINS-1:0]             evt_pin, lvl_act_pin, cond_pin;

  pis_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .cur_o (cur_pin),
    .prev_o(prev_pin)
  );

  pis_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .cur_i    (cur_pin),
    .prev_i   (prev_pin),
    .mode_i   (mode_pin),
    .kind_i   (kind_pin),
    .evt_o    (evt_pin),
    .lvl_act_o(lvl_act_pin),
    .cond_o   (cond_pin)
  );

  pis_pending #(.NUM_PINS(NUM_PINS)) u_pending (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_pin),
    .lvl_act_i(lvl_act_pin),
    .cond_i   (cond_pin),
    .clr_i    (clr_pin),
    .pend_o   (pend_pin)
  );

  pis_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .pend_i (pend_pin),
    .rdata_o(rdata_o),
    .mask_o (mask_pin),
    .kind_o (kind_pin),
    .mode_o (mode_pin),
    .clr_o  (clr_pin)
  );

  assign irq_o = |(pend_pin & mask_pin);
endmodule

// File: rtl/pis_checker.sv
module pis_checker
  import pis_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            we_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [DATA_W-1:0]               wdata_i,
  input logic                            irq_o,
  input logic [NUM_PINS-1:0]             pend_q,
  input logic [NUM_PINS-1:0]             mask_q,
  input logic [NUM_PINS-1:0][MODE_W-1:0] mode_q,
  input logic [NUM_PINS-1:0]             evt,
  input logic [NUM_PINS-1:0]             lvl_act,
  input logic [NUM_PINS-1:0]             cond
);
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R9

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic clr_hit;
    assign clr_hit = we_i && (addr_i == ADDR_W'(OFS_PEND)) && wdata_i[DATA_W-1-p];

    AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(mode_q[p] == 2'b11) |-> !$rose(pend_q[p])); // R7
    AST_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(lvl_act[p] && cond[p]) |-> pend_q[p]); // R6
    AST_LEVEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(lvl_act[p] && !cond[p]) |-> !pend_q[p]); // R6
    AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(pend_q[p] && !lvl_act[p] && !clr_hit) |-> pend_q[p]); // R8
    AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[p]) |-> $past(evt[p] || (lvl_act[p] && cond[p]))); // R10
  end
endmodule

bind pin_irq_sense pis_checker #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .pend_q (pend_pin),
  .mask_q (mask_pin),
  .mode_q (mode_pin),
  .evt    (evt_pin),
  .lvl_act(lvl_act_pin),
  .cond   (cond_pin)
);

// File: tb/pin_irq_sense_tb_top.sv
`timescale 1ns/1ps
module pin_irq_sense_tb_top;
  localparam logic [4:0] A_PEND = 5'h00, A_MASK = 5'h04, A_KIND = 5'h08;
  localparam logic [4:0] A_LO = 5'h14, A_HI = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_irq_sense dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] pbit(int p);
    return 32'h8000_0000 >> p;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_mode(int p, logic [1:0] m);
    logic [31:0] w;
    logic [4:0] a;
    int sh;
    a = (p < 16) ? A_LO : A_HI;
    sh = (15 - (p % 16)) * 2;
    reg_rd(a, w);
    w = (w & ~(32'h3 << sh)) | (32'(m) << sh);
    reg_wr(a, w);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(A_PEND, d); check("R1 pend", d, 0);
    reg_rd(A_MASK, d); check("R1 mask", d, 0);
    reg_rd(A_KIND, d); check("R1 kind", d, 0);
    reg_rd(A_LO, d);   check("R1 mode_lo", d, 0);
    reg_rd(A_HI, d);   check("R1 mode_hi", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    reg_wr(A_MASK, 32'hA5A5_0F0F); reg_rd(A_MASK, d); check("R2 mask rb", d, 32'hA5A5_0F0F);
    reg_wr(A_KIND, 32'h1234_5678); reg_rd(A_KIND, d); check("R2 kind rb", d, 32'h1234_5678);
    reg_wr(A_LO, 32'hDEAD_BEEF);   reg_rd(A_LO, d);   check("R2 lo rb", d, 32'hDEAD_BEEF);
    reg_wr(A_HI, 32'h0BAD_F00D);   reg_rd(A_HI, d);   check("R2 hi rb", d, 32'h0BAD_F00D);
    reg_wr(5'h1C, 32'hFFFF_FFFF);  reg_rd(5'h1C, d);  check("R2 hole", d, 0);
    reg_rd(A_MASK, d); check("R2 hole no side effect", d, 32'hA5A5_0F0F);
    reg_wr(A_MASK, 0); reg_wr(A_KIND, 0); reg_wr(A_LO, 0); reg_wr(A_HI, 0);
    reg_wr(A_PEND, 32'hFFFF_FFFF);
    reg_rd(A_PEND, d); check("R2 clean", d, 0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    pins[5] = 1'b1;                                   // any-edge pin 5
    tick(1); reg_rd(A_PEND, d); check("R10 edge+1", d, 0);
    tick(1); reg_rd(A_PEND, d); check("R10 edge+2", d, 0);
    tick(1); reg_rd(A_PEND, d); check("R3 R10 edge+3 bit26", d, pbit(5));
    reg_wr(A_PEND, pbit(5)); reg_rd(A_PEND, d); check("R8 w1c", d, 0);
    set_mode(5, 2'b01); tick(4); reg_rd(A_PEND, d); check("R10 mode change hi", d, 0);
    set_mode(5, 2'b10); tick(4); reg_rd(A_PEND, d); check("R10 mode change lo", d, 0);
    reg_wr(A_KIND, pbit(5)); reg_wr(A_KIND, 0); tick(4);
    reg_rd(A_PEND, d); check("R10 kind change", d, 0);
    set_mode(5, 2'b00);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    pins[5] = 1'b0; tick(4); reg_rd(A_PEND, d); check("R4 fall", d, pbit(5));
    reg_wr(A_PEND, pbit(5));
    reg_wr(A_KIND, pbit(5));                          // kind ignored in mode 00
    pins[5] = 1'b1; tick(4); reg_rd(A_PEND, d); check("R4 kind1 rise", d, pbit(5));
    reg_wr(A_PEND, pbit(5)); reg_rd(A_PEND, d); check("R4 kind1 clear", d, 0);
    reg_wr(A_KIND, 0);
    set_mode(9, 2'b01);
    pins[9] = 1'b1; tick(4); reg_rd(A_PEND, d); check("R5 rise", d, pbit(9));
    reg_wr(A_PEND, pbit(9));
    pins[9] = 1'b0; tick(4); reg_rd(A_PEND, d); check("R5 no fall", d, 0);
    set_mode(20, 2'b10);
    pins[20] = 1'b1; tick(4); reg_rd(A_PEND, d); check("R5 no rise", d, 0);
    pins[20] = 1'b0; tick(4); reg_rd(A_PEND, d); check("R3 R5 fall hi word", d, pbit(20));
    reg_wr(A_PEND, pbit(20));
    set_mode(9, 2'b00); set_mode(20, 2'b00);
  endtask

  task automatic t_level;
    logic [31:0] d;
    set_mode(12, 2'b01); reg_wr(A_KIND, pbit(12));
    pins[12] = 1'b1; tick(4); reg_rd(A_PEND, d); check("R6 high", d, pbit(12));
    reg_wr(A_PEND, pbit(12)); reg_rd(A_PEND, d); check("R6 w1c held", d, pbit(12));
    pins[12] = 1'b0; tick(4); reg_rd(A_PEND, d); check("R6 drop", d, 0);
    set_mode(12, 2'b10); tick(2); reg_rd(A_PEND, d); check("R6 low", d, pbit(12));
    pins[12] = 1'b1; tick(4); reg_rd(A_PEND, d); check("R6 low drop", d, 0);
    reg_wr(A_KIND, 0); set_mode(12, 2'b00); pins[12] = 1'b0; tick(4);
    reg_wr(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic t_rsvd;
    logic [31:0] d;
    set_mode(30, 2'b11);
    pins[30] = 1'b1; tick(4); pins[30] = 1'b0; tick(4);
    reg_rd(A_PEND, d); check("R7 edge kind", d, 0);
    reg_wr(A_KIND, pbit(30)); tick(4);
    pins[30] = 1'b1; tick(4);
    reg_rd(A_PEND, d); check("R7 level kind", d, 0);
    reg_wr(A_KIND, 0); pins[30] = 1'b0; tick(4);
    set_mode(30, 2'b00);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pins[7] = 1'b1; tick(4);
    reg_wr(A_PEND, 32'h0); reg_rd(A_PEND, d); check("R8 zero write", d, pbit(7));
    pins[7] = 1'b0;                                   // event lands at 3rd edge
    tick(2);
    we = 1'b1; addr = A_PEND; wdata = pbit(7);
    tick(1); we = 1'b0;
    reg_rd(A_PEND, d); check("R8 event beats clear", d, pbit(7));
    tick(2); reg_wr(A_PEND, pbit(7)); reg_rd(A_PEND, d); check("R8 clear after", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pins[7] = 1'b1; tick(4);
    reg_rd(A_PEND, d); check("R9 setup", d, pbit(7));
    #1 check("R9 masked", 32'(irq), 0);
    reg_wr(A_MASK, ~pbit(7)); #1 check("R9 other mask", 32'(irq), 0);
    reg_wr(A_MASK, pbit(7));  #1 check("R9 unmasked", 32'(irq), 1);
    reg_wr(A_PEND, pbit(7));  #1 check("R9 cleared", 32'(irq), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_latency();
    t_edges();
    t_level();
    t_rsvd();
    t_race();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule